// File: doc/BRIEF.md
# Write-Protected Sensor Configuration Register Bank

This block holds the byte-wide configuration of a sensor-conditioning datapath. A host reaches it through a plain strobe interface: an address, write data, a write strobe, a read strobe, read data and an acknowledge that marks each byte the bank took. Six control registers sit at 0x80 to 0x85. A volatile write-enable latch sits at 0x86. A read-only status location at 0x87 returns the current 8-bit converter sample.

The latch protects the whole bank. It comes out of reset clear, and while it is clear every write to a control register is dropped and gets no acknowledge. The latch changes only on one of two exact byte values written to 0x86. Two select bits in the register at 0x85 steer the datapath. The first decides whether the 64-row table is indexed by the upper six bits of the sample or by a 6-bit direct field. The second decides whether the output word is the addressed table row or the byte held at 0x84. The table contents and the sample arrive on input ports.

Top module: `scfg_regbank`

## Requirements
- R1: After reset the latch is clear, every control register holds 0x00, `host_ack` is 0, `host_rdata` is 0x00, the table index is `adc_sample[7:2]` and `out_word` equals `tbl_row_data`.
- R2: A write of exactly 0x80 to 0x86 sets the latch and a write of exactly 0x00 clears it. Both are acknowledged whatever the latch state. Reading 0x86 returns the latch in bit 7, with bits 6:0 always 0.
- R3: While the latch is clear, a write to a control register (0x80–0x85) leaves every register unchanged and is not acknowledged.
- R4: While the latch is set, a write to a control register stores the byte and is acknowledged. A later read returns that byte.
- R5: A write of any other value to 0x86 leaves the latch unchanged. It is acknowledged only if the latch is already set.
- R6: A read of 0x87 returns the `adc_sample` value present during the strobe cycle. A write to 0x87 changes nothing and is never acknowledged.
- R7: A read of an address outside 0x80–0x87 returns 0x00 with acknowledge. A write to such an address changes nothing and is not acknowledged.
- R8: With bit 7 of 0x85 at 0, `tbl_row_idx` is `adc_sample[7:2]`. With it at 1, `tbl_row_idx` is bits 5:0 of 0x85.
- R9: With bit 6 of 0x85 at 0, `out_word` is `tbl_row_data`. With it at 1, `out_word` is the register at 0x84.
- R10: `host_ack` and `host_rdata` are registered and valid in the cycle after the strobe. A register or latch update takes effect at the clock edge that ends the strobe cycle, so `tbl_row_idx` and `out_word` show it from the next cycle and not during the strobe cycle.
- R11: If `host_wr` and `host_rd` are asserted together, only the write is performed and `host_rdata` returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_rdata | output | 8 | Read data, valid with the acknowledge |
| host_ack | output | 1 | Acknowledge for the byte strobed in the previous cycle |
| adc_sample | input | 8 | Converter sample, 0x00 minimum to 0xFF full scale |
| tbl_row_data | input | 8 | Content of the addressed table row |
| tbl_row_idx | output | 6 | Table row index |
| out_word | output | 8 | Selected output word |

## Verification
Properties check four things on every cycle. The latch holds unless one of its two codes is written, and the set code always sets it. No register moves and no acknowledge appears for a write made while the bank is locked. Writes to the status location are never acknowledged. Every acknowledge is traced back to a strobe. Only the bench scenarios can show the rest. These are the stored and returned data, the decode of each address class and the acknowledge for odd codes at 0x86. They also cover both settings of each mux select, the exact cycle in which the mux outputs change, and the result when both strobes are asserted at once.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        AK_NONE = 2'd0,
        AK_CTRL = 2'd1,
        AK_WEL  = 2'd2,
        AK_STAT = 2'd3
    } addr_kind_e;

    typedef struct packed {
        logic  ack;
        byte_t rdata;
    } host_resp_t;
endpackage

// File: rtl/scfg_wel.sv
module scfg_wel
    import scfg_pkg::*;
#(
    parameter byte_t SET_CODE = 8'h80,
    parameter byte_t CLR_CODE = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  byte_t wdata,
    output logic  wel,
    output logic  code_hit
);
    typedef struct packed {
        logic wel;
    } wel_state_t;

    wel_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        code_hit = (wdata == SET_CODE) || (wdata == CLR_CODE);
        if (wr && (wdata == SET_CODE)) begin
            st_d.wel = 1'b1;
        end else if (wr && (wdata == CLR_CODE)) begin
            st_d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wel = st_q.wel;

    // R2 / R5: only the two exact codes move the latch
    p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && ((wdata == SET_CODE) || (wdata == CLR_CODE))) |=> $stable(wel))
        else $error("latch moved without a code");

    p_set_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata == SET_CODE)) |=> wel)
        else $error("set code did not set latch");
endmodule

// File: rtl/scfg_regfile.sv
module scfg_regfile
    import scfg_pkg::*;
#(
    parameter int unsigned NUM_CTRL = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [NUM_CTRL-1:0]              sel,
    input  byte_t                            wdata,
    output logic [NUM_CTRL-1:0][BYTE_W-1:0]  regs,
    output byte_t                            rd_byte
);
    typedef struct packed {
        logic [NUM_CTRL-1:0][BYTE_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_byte = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (we && sel[i]) begin
                st_d.regs[i] = wdata;
            end
            if (sel[i]) begin
                rd_byte = rd_byte | st_q.regs[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.regs;

    p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel))
        else $error("overlapping register selects");
endmodule

// File: rtl/scfg_host_resp.sv
module scfg_host_resp
    import scfg_pkg::*;
#(
    parameter int unsigned WEL_BIT = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       rd,
    input  addr_kind_e kind,
    input  byte_t      ctrl_byte,
    input  logic       wel,
    input  logic       code_hit,
    input  byte_t      sample,
    output logic       ack,
    output byte_t      rdata
);
    host_resp_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (wr) begin
            unique case (kind)
                AK_CTRL: st_d.ack = wel;
                AK_WEL:  st_d.ack = code_hit || wel;
                AK_STAT: st_d.ack = 1'b0;
                default: st_d.ack = 1'b0;
            endcase
        end else if (rd) begin
            st_d.ack = 1'b1;
            unique case (kind)
                AK_CTRL: st_d.rdata = ctrl_byte;
                AK_WEL:  st_d.rdata[WEL_BIT] = wel;
                AK_STAT: st_d.rdata = sample;
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack   = st_q.ack;
    assign rdata = st_q.rdata;

    p_ack_from_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(wr || rd))
        else $error("acknowledge without a strobe");
endmodule

// File: rtl/scfg_lut_mux.sv
module scfg_lut_mux
    import scfg_pkg::*;
#(
    parameter int unsigned ROW_W = 6
) (
    input  logic [ROW_W-1:0] sample_msb,
    input  logic [ROW_W-1:0] direct_idx,
    input  logic             idx_direct,
    input  logic             out_direct,
    input  byte_t            tbl_data,
    input  byte_t            direct_word,
    output logic [ROW_W-1:0] row_idx,
    output byte_t            word
);
    always_comb begin
        row_idx = idx_direct ? direct_idx  : sample_msb;
        word    = out_direct ? direct_word : tbl_data;
    end
endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank
    import scfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned NUM_CTRL    = 6,
    parameter int unsigned ROW_W       = 6,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 8'h80,
    parameter logic [ADDR_W-1:0] WEL_ADDR  = 8'h86,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h87,
    parameter byte_t SET_CODE    = 8'h80,
    parameter byte_t CLR_CODE    = 8'h00,
    parameter int unsigned OUT_REG     = 4,
    parameter int unsigned SEL_REG     = 5,
    parameter int unsigned IDX_SEL_BIT = 7,
    parameter int unsigned OUT_SEL_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    output logic              host_ack,
    input  logic [7:0]        adc_sample,
    input  logic [7:0]        tbl_row_data,
    output logic [ROW_W-1:0]  tbl_row_idx,
    output logic [7:0]        out_word
);
    localparam int unsigned WEL_BIT = BYTE_W - 1;

    addr_kind_e                      kind;
    logic [NUM_CTRL-1:0]             ctrl_sel;
    logic [NUM_CTRL-1:0][BYTE_W-1:0] ctrl_regs;
    byte_t                           ctrl_byte;
    logic                            wel;
    logic                            code_hit;

    always_comb begin
        ctrl_sel = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            ctrl_sel[i] = (host_addr == CTRL_BASE + ADDR_W'(i));
        end
        if (|ctrl_sel)                   kind = AK_CTRL;
        else if (host_addr == WEL_ADDR)  kind = AK_WEL;
        else if (host_addr == STAT_ADDR) kind = AK_STAT;
        else                             kind = AK_NONE;
    end

    scfg_wel #(
        .SET_CODE (SET_CODE),
        .CLR_CODE (CLR_CODE)
    ) u_wel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr && (kind == AK_WEL)),
        .wdata    (host_wdata),
        .wel      (wel),
        .code_hit (code_hit)
    );

    scfg_regfile #(
        .NUM_CTRL (NUM_CTRL)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (host_wr && wel),
        .sel     (ctrl_sel),
        .wdata   (host_wdata),
        .regs    (ctrl_regs),
        .rd_byte (ctrl_byte)
    );

    scfg_host_resp #(
        .WEL_BIT (WEL_BIT)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_wr),
        .rd        (host_rd),
        .kind      (kind),
        .ctrl_byte (ctrl_byte),
        .wel       (wel),
        .code_hit  (code_hit),
        .sample    (adc_sample),
        .ack       (host_ack),
        .rdata     (host_rdata)
    );

    scfg_lut_mux #(
        .ROW_W (ROW_W)
    ) u_mux (
        .sample_msb  (adc_sample[BYTE_W-1 -: ROW_W]),
        .direct_idx  (ctrl_regs[SEL_REG][ROW_W-1:0]),
        .idx_direct  (ctrl_regs[SEL_REG][IDX_SEL_BIT]),
        .out_direct  (ctrl_regs[SEL_REG][OUT_SEL_BIT]),
        .tbl_data    (tbl_row_data),
        .direct_word (ctrl_regs[OUT_REG]),
        .row_idx     (tbl_row_idx),
        .word        (out_word)
    );

    // R3: a locked bank neither changes nor acknowledges control writes
    p_locked_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !wel) |=> $stable(ctrl_regs))
        else $error("register changed while locked");

    p_locked_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !wel && (host_addr != WEL_ADDR)) |=> !host_ack)
        else $error("locked write acknowledged");

    // R6: the status location never acknowledges a write
    p_status_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_addr == STAT_ADDR)) |=> !host_ack)
        else $error("status write acknowledged");
endmodule

// File: tb/scfg_regbank_bench.sv
module scfg_regbank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_ack;
    logic [7:0] adc_sample = 8'hB4;
    logic [7:0] tbl_row_data;
    logic [5:0] tbl_row_idx;
    logic [7:0] out_word;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic       ack;
        logic       chk_data;
        logic [7:0] data;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    // table model: each row holds a value derived from its index
    assign tbl_row_data = {tbl_row_idx, 2'b11} ^ 8'h5A;

    scfg_regbank u_scfg_regbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_rdata   (host_rdata),
        .host_ack     (host_ack),
        .adc_sample   (adc_sample),
        .tbl_row_data (tbl_row_data),
        .tbl_row_idx  (tbl_row_idx),
        .out_word     (out_word)
    );

    function automatic logic [7:0] tbl_of(input logic [5:0] idx);
        return {idx, 2'b11} ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // driver: one strobe cycle, expectation pushed to the scoreboard
    task automatic xact(input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] d,
                        input bit eack, input bit chk, input logic [7:0] edata, input string tag);
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
        exp_q.push_back('{ack: eack, chk_data: chk, data: edata});
        tag_q.push_back(tag);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic wr_b(input logic [7:0] a, input logic [7:0] d, input bit eack, input string tag);
        xact(1'b1, 1'b0, a, d, eack, 1'b0, 8'h00, tag);
    endtask

    task automatic rd_b(input logic [7:0] a, input logic [7:0] edata, input string tag);
        xact(1'b0, 1'b1, a, 8'h00, 1'b1, 1'b1, edata, tag);
    endtask

    // monitor: compares the response one cycle after each strobe
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(host_ack == e.ack, {t, " ack"}, int'(host_ack), int'(e.ack));
            if (e.chk_data) begin
                check(host_rdata == e.data, {t, " rdata"}, int'(host_rdata), int'(e.data));
            end
        end
    end

    task automatic check_mux(input logic [5:0] eidx, input logic [7:0] eword, input string tag);
        check(tbl_row_idx == eidx, {tag, " idx"}, int'(tbl_row_idx), int'(eidx));
        check(out_word == eword, {tag, " word"}, int'(out_word), int'(eword));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(host_ack == 1'b0, "R1 ack", int'(host_ack), 0);
        check(host_rdata == 8'h00, "R1 rdata", int'(host_rdata), 0);
        check_mux(6'h2D, tbl_of(6'h2D), "R1");
        rd_b(8'h84, 8'h00, "R1 reg 0x84");
        rd_b(8'h86, 8'h00, "R1 latch");

        // R3 locked writes
        wr_b(8'h84, 8'h3C, 1'b0, "R3 locked write");
        rd_b(8'h84, 8'h00, "R3 locked readback");
        wr_b(8'h85, 8'hC5, 1'b0, "R3 locked select write");
        check_mux(6'h2D, tbl_of(6'h2D), "R3 mux unchanged");
        // R5 odd code while clear
        wr_b(8'h86, 8'h55, 1'b0, "R5 odd code locked");
        rd_b(8'h86, 8'h00, "R5 latch still clear");

        // R2 set
        wr_b(8'h86, 8'h80, 1'b1, "R2 set code");
        rd_b(8'h86, 8'h80, "R2 latch set");
        // R5 odd code while set
        wr_b(8'h86, 8'h55, 1'b1, "R5 odd code set");
        rd_b(8'h86, 8'h80, "R5 latch kept");
        wr_b(8'h86, 8'h81, 1'b1, "R5 near code");
        rd_b(8'h86, 8'h80, "R5 latch kept 2");

        // R4 stores
        wr_b(8'h84, 8'h3C, 1'b1, "R4 write 0x84");
        rd_b(8'h84, 8'h3C, "R4 read 0x84");
        for (int i = 0; i < 4; i++) begin
            wr_b(8'h80 + 8'(i), 8'hA0 + 8'(i * 17), 1'b1, "R4 write low regs");
        end
        for (int i = 0; i < 4; i++) begin
            rd_b(8'h80 + 8'(i), 8'hA0 + 8'(i * 17), "R4 read low regs");
        end

        // R6 status
        rd_b(8'h87, 8'hB4, "R6 status");
        adc_sample = 8'hFF;
        rd_b(8'h87, 8'hFF, "R6 full scale");
        check_mux(6'h3F, tbl_of(6'h3F), "R8 sample index full scale");
        adc_sample = 8'h00;
        rd_b(8'h87, 8'h00, "R6 minimum");
        wr_b(8'h87, 8'h99, 1'b0, "R6 status write");
        rd_b(8'h87, 8'h00, "R6 status unchanged");
        adc_sample = 8'hB4;

        // R7 undefined addresses
        rd_b(8'h90, 8'h00, "R7 read 0x90");
        wr_b(8'h90, 8'h77, 1'b0, "R7 write 0x90");
        wr_b(8'h7F, 8'h77, 1'b0, "R7 write 0x7F");
        rd_b(8'h7F, 8'h00, "R7 read 0x7F");
        rd_b(8'h00, 8'h00, "R7 read 0x00");

        // R10 / R8: select direct index, observe the exact edge
        @(negedge clk);
        host_wr = 1'b1; host_addr = 8'h85; host_wdata = 8'h95;
        exp_q.push_back('{ack: 1'b1, chk_data: 1'b0, data: 8'h00});
        tag_q.push_back("R10 select write");
        #1;
        check_mux(6'h2D, tbl_of(6'h2D), "R10 before edge");
        @(posedge clk);
        #1;
        check_mux(6'h15, tbl_of(6'h15), "R8 direct index");
        @(negedge clk);
        host_wr = 1'b0;
        adc_sample = 8'h40;
        #1;
        check_mux(6'h15, tbl_of(6'h15), "R8 direct ignores sample");

        // R9 output source
        wr_b(8'h85, 8'hD5, 1'b1, "R9 select reg word");
        check_mux(6'h15, 8'h3C, "R9 word from 0x84");
        wr_b(8'h85, 8'h40, 1'b1, "R9 sample index reg word");
        check_mux(6'h10, 8'h3C, "R9 R8 combined");
        wr_b(8'h84, 8'hE7, 1'b1, "R9 update 0x84");
        check_mux(6'h10, 8'hE7, "R9 follows 0x84");
        wr_b(8'h85, 8'h00, 1'b1, "R9 back to table");
        check_mux(6'h10, tbl_of(6'h10), "R9 table word");

        // R11 both strobes
        xact(1'b1, 1'b1, 8'h83, 8'h5E, 1'b1, 1'b1, 8'h00, "R11 both strobes");
        rd_b(8'h83, 8'h5E, "R11 write performed");

        // R2 clear, then locked again
        wr_b(8'h86, 8'h00, 1'b1, "R2 clear code");
        rd_b(8'h86, 8'h00, "R2 latch clear");
        wr_b(8'h84, 8'h11, 1'b0, "R3 relocked write");
        rd_b(8'h84, 8'hE7, "R3 relocked readback");
        wr_b(8'h86, 8'h00, 1'b1, "R2 clear while clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule